// File: doc/BRIEF.md
# Identifier Search Triplet Sequencer

This block carries out a single decision step of the device-identifier search on a single-wire bus. Every device still taking part answers two read slots: first with its current identifier bit, then with the inverse of that bit. Because the bus is a wired-AND, the two values the master sees show whether all remaining devices agree on the bit, whether they split, or whether none is answering.

From the pair of bits and a preferred-direction input, the sequencer picks the branch to follow. Unless nobody answered, it then issues one write slot that carries the chosen bit, so that devices on the other branch drop out. The bit-level timing is left to a separate slot engine, which the block drives through a request/acknowledge handshake. The caller gets back a registered 3-bit status together with a one-cycle completion pulse. The outer 64-step loop, discrepancy tracking and CRC checking sit in the caller.

Top module: `srch_triplet`

## Requirements
- R1: After an accepted start, the block requests exactly two read slots (`slot_wr`=0) before anything else. The first returned `slot_rbit` is taken as the identifier bit and the second as the complement bit. `slot_req` stays high, with `slot_wr` stable, until a cycle in which `slot_ack` is high, and `slot_rbit` is sampled in that acknowledge cycle.
- R2: The status is packed with the identifier bit in bit 0, the complement bit in bit 1 and the direction taken in bit 2. Only the codes 000, 010, 011, 100 and 101 are ever reported.
- R3: If both read bits are 1, the status is 3'b011 and no write slot is requested.
- R4: If both read bits are 0, the direction equals `pref_dir` as sampled at start. The status is 3'b100 for direction 1 and 3'b000 for direction 0.
- R5: If exactly one read bit is 1, the direction equals the identifier bit. The status is 3'b101 when the identifier bit is 1 and 3'b010 when it is 0.
- R6: Outside the R3 case, a single write slot (`slot_wr`=1) follows the two reads, and its `slot_wbit` equals status bit 2.
- R7: `done` is high for exactly one clock. It rises in the cycle after the write slot's acknowledge, or in the cycle after the second read's acknowledge in the R3 case. `status` is valid in that same cycle.
- R8: `status` holds its value after `done` until the next accepted start, which clears it to 3'b000.
- R9: A `start` that arrives while a triplet is in progress is ignored. Neither the slot sequence nor the direction used changes.
- R10: While `rst_n` is low, and after it is released, the block is idle: `slot_req`=0, `done`=0 and `status`=3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Begin one triplet; accepted only while idle |
| pref_dir | input | 1 | Preferred direction when devices disagree, sampled with start |
| slot_req | output | 1 | Slot request to the bit engine, held until acknowledged |
| slot_wr | output | 1 | Slot kind: 0 read slot, 1 write slot |
| slot_wbit | output | 1 | Bit to send in a write slot |
| slot_ack | input | 1 | Bit engine reports the current slot finished |
| slot_rbit | input | 1 | Level sampled by the bit engine, valid with slot_ack |
| status | output | 3 | {direction, complement bit, identifier bit} |
| done | output | 1 | One-cycle pulse when status is valid |

## Verification
The hardest situation to reach from the ports is a second `start` that lands in the middle of a triplet with a different preferred direction. Sampling `pref_dir` at the wrong moment would quietly flip the branch. The bench's slot-engine model stretches each slot over several cycles, and the stimulus raises `start` with the opposite `pref_dir` while the complement read is pending, with both read bits 0. That is the one case where the preferred direction reaches the write bit and the status. The engine model also counts reads and writes and records their order, so a missing or extra write slot in the all-ones case shows up.

// File: rtl/trip_pkg.sv
package trip_pkg;

  localparam int unsigned STAT_W = 3;

  localparam int unsigned ST_ID_BIT  = 0;
  localparam int unsigned ST_CMP_BIT = 1;
  localparam int unsigned ST_DIR_BIT = 2;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_RD_ID  = 2'd1,
    PH_RD_CMP = 2'd2,
    PH_WR_DIR = 2'd3
  } trip_phase_e;

  localparam logic [STAT_W-1:0] CODE_NONE = 3'b011;

endpackage

// File: rtl/trip_rst_sync.sv
module trip_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_q_n = sync_q[STAGES-1];

endmodule

// File: rtl/trip_decide.sv
module trip_decide
  import trip_pkg::*;
(
  input  logic              id_bit,
  input  logic              cmp_bit,
  input  logic              pref,
  output logic              dir,
  output logic              none_resp,
  output logic [STAT_W-1:0] code
);

  always_comb begin
    none_resp = id_bit & cmp_bit;
    if (!id_bit && !cmp_bit) begin
      dir = pref;
    end else begin
      dir = id_bit;
    end
    code              = '0;
    code[ST_ID_BIT]   = id_bit;
    code[ST_CMP_BIT]  = cmp_bit;
    code[ST_DIR_BIT]  = none_resp ? 1'b0 : dir;
  end

endmodule

// File: rtl/trip_seq.sv
module trip_seq
  import trip_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pref_dir,
  input  logic              slot_ack,
  input  logic              slot_rbit,
  output logic              slot_req,
  output logic              slot_wr,
  output logic              slot_wbit,
  output logic              accept,
  output logic              finish,
  output logic [STAT_W-1:0] final_code
);

  trip_phase_e phase_q, phase_d;
  logic        id_q, cmp_q, pref_q;
  logic        id_en, cmp_en, pref_en;
  logic        cmp_now;
  logic        dir_w, none_w;

  trip_decide u_decide (
    .id_bit    (id_q),
    .cmp_bit   (cmp_now),
    .pref      (pref_q),
    .dir       (dir_w),
    .none_resp (none_w),
    .code      (final_code)
  );

  always_comb begin
    cmp_now = (phase_q == PH_RD_CMP) ? slot_rbit : cmp_q;
    accept  = (phase_q == PH_IDLE) && start;
    id_en   = (phase_q == PH_RD_ID) && slot_ack;
    cmp_en  = (phase_q == PH_RD_CMP) && slot_ack;
    pref_en = accept;
    finish  = ((phase_q == PH_RD_CMP) && slot_ack && none_w) ||
              ((phase_q == PH_WR_DIR) && slot_ack);
  end

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE:   if (start)    phase_d = PH_RD_ID;
      PH_RD_ID:  if (slot_ack) phase_d = PH_RD_CMP;
      PH_RD_CMP: if (slot_ack) phase_d = none_w ? PH_IDLE : PH_WR_DIR;
      PH_WR_DIR: if (slot_ack) phase_d = PH_IDLE;
      default:                 phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q <= 1'b0;
    end else if (id_en) begin
      id_q <= slot_rbit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= 1'b0;
    end else if (cmp_en) begin
      cmp_q <= slot_rbit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pref_q <= 1'b0;
    end else if (pref_en) begin
      pref_q <= pref_dir;
    end
  end

  assign slot_req  = (phase_q != PH_IDLE);
  assign slot_wr   = (phase_q == PH_WR_DIR);
  assign slot_wbit = (phase_q == PH_WR_DIR) ? dir_w : 1'b0;

  // R1: a pending request is held, kind unchanged, until acknowledged
  assert_req_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && !slot_ack) |=> (slot_req && $stable(slot_wr)));

  // R9: start while busy leaves the captured preference untouched
  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && !finish) |=> $stable(pref_q));

  // R3: no write slot follows when both reads returned 1
  assert_no_write_on_none_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && !slot_wr && slot_ack && id_q && slot_rbit && phase_q == PH_RD_CMP) |=> !slot_req);

endmodule

// File: rtl/trip_status.sv
module trip_status
  import trip_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              finish,
  input  logic [STAT_W-1:0] final_code,
  output logic [STAT_W-1:0] status,
  output logic              done
);

  logic [STAT_W-1:0] stat_q, stat_d;
  logic              stat_en;
  logic              done_q;

  always_comb begin
    stat_en = accept | finish;
    stat_d  = finish ? final_code : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
    end
  end

  assign status = stat_q;
  assign done   = done_q;

  // R7: completion pulse lasts one clock
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: status only moves on start acceptance or completion
  assert_status_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !finish) |=> $stable(status));

endmodule

// File: rtl/srch_triplet.sv
module srch_triplet
  import trip_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pref_dir,
  output logic              slot_req,
  output logic              slot_wr,
  output logic              slot_wbit,
  input  logic              slot_ack,
  input  logic              slot_rbit,
  output logic [STAT_W-1:0] status,
  output logic              done
);

  logic              rst_q_n;
  logic              accept, finish;
  logic [STAT_W-1:0] final_code;

  trip_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  trip_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .start      (start),
    .pref_dir   (pref_dir),
    .slot_ack   (slot_ack),
    .slot_rbit  (slot_rbit),
    .slot_req   (slot_req),
    .slot_wr    (slot_wr),
    .slot_wbit  (slot_wbit),
    .accept     (accept),
    .finish     (finish),
    .final_code (final_code)
  );

  trip_status u_stat (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .accept     (accept),
    .finish     (finish),
    .final_code (final_code),
    .status     (status),
    .done       (done)
  );

  // R2: only the five legal codes are reported on completion
  assert_legal_code_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    done |-> (status == 3'b000 || status == 3'b010 || status == CODE_NONE ||
              status == 3'b100 || status == 3'b101));

  // R6: write bit of the last slot matches the reported direction
  assert_wbit_matches_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (done && status != CODE_NONE) |-> ($past(slot_wr) && $past(slot_wbit) == status[ST_DIR_BIT]));

  // R10: idle after reset
  assert_idle_reset_R10: assert property (@(posedge clk)
    !rst_q_n |-> (!slot_req && !done && status == '0));

endmodule

// File: tb/srch_triplet_bench.sv
module srch_triplet_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start, pref_dir;
  logic       slot_req, slot_wr, slot_wbit;
  logic       slot_ack, slot_rbit;
  logic [2:0] status;
  logic       done;

  int tests = 0;
  int fails = 0;

  logic id_v, cmp_v;
  int   rd_idx, n_wr, lat, order_bad;
  logic last_wbit;

  always #4 clk = ~clk;

  srch_triplet u_srch_triplet (
    .clk(clk), .rst_n(rst_n), .start(start), .pref_dir(pref_dir),
    .slot_req(slot_req), .slot_wr(slot_wr), .slot_wbit(slot_wbit),
    .slot_ack(slot_ack), .slot_rbit(slot_rbit), .status(status), .done(done)
  );

  // slot engine model: acknowledges each request after a few cycles
  initial begin
    slot_ack = 1'b0; slot_rbit = 1'b0; lat = 0;
    forever begin
      @(negedge clk);
      if (slot_ack) begin
        slot_ack = 1'b0; slot_rbit = 1'b0; lat = 0;
      end else if (slot_req) begin
        if (lat == 3) begin
          slot_ack = 1'b1;
          if (slot_wr) begin
            if (rd_idx != 2) order_bad++;
            n_wr++; last_wbit = slot_wbit;
          end else begin
            slot_rbit = (rd_idx == 0) ? id_v : cmp_v;
            rd_idx++;
          end
        end else lat++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
    end
  endtask

  task automatic pulse_start(input logic p);
    @(negedge clk); start = 1'b1; pref_dir = p;
    @(negedge clk); start = 1'b0; pref_dir = ~p;
  endtask

  task automatic run_case(input logic p, input logic id, input logic cmp,
                          input logic [2:0] exp, input int exp_wr, input string req,
                          input bit busy_poke);
    bit seen;
    id_v = id; cmp_v = cmp; rd_idx = 0; n_wr = 0; order_bad = 0; last_wbit = 1'b0;
    pulse_start(p);
    chk(status == 3'b000, "R8 clear on start", status, 0);
    if (busy_poke) begin
      repeat (6) @(negedge clk);
      start = 1'b1; pref_dir = ~p;
      @(negedge clk); start = 1'b0;
    end
    wait_done(seen);
    chk(seen, {req, " done seen"}, seen, 1);
    chk(status == exp, {req, " status"}, status, exp);
    chk(rd_idx == 2, "R1 two reads", rd_idx, 2);
    chk(n_wr == exp_wr, {req, " write count"}, n_wr, exp_wr);
    chk(order_bad == 0, "R1 reads before write", order_bad, 0);
    if (exp_wr == 1) chk(last_wbit == exp[2], "R6 write bit", last_wbit, exp[2]);
    @(negedge clk);
    chk(!done, "R7 one cycle done", done, 0);
    repeat (4) @(negedge clk);
    chk(status == exp, "R8 status held", status, exp);
    chk(!slot_req, "R9 no extra slot", slot_req, 0);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; start = 1'b0; pref_dir = 1'b0;
    id_v = 1'b0; cmp_v = 1'b0; rd_idx = 0; n_wr = 0;
    repeat (3) @(negedge clk);
    chk(!slot_req && !done && status == 3'b000, "R10 in reset", status, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!slot_req && !done && status == 3'b000, "R10 after release", {slot_req, done}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    test_reset();
    run_case(1'b1, 1'b1, 1'b1, 3'b011, 0, "R3 none answer", 0);
    run_case(1'b0, 1'b1, 1'b1, 3'b011, 0, "R3 none answer pref0", 0);
    run_case(1'b1, 1'b0, 1'b0, 3'b100, 1, "R4 split pref1", 0);
    run_case(1'b0, 1'b0, 1'b0, 3'b000, 1, "R4 split pref0", 0);
    run_case(1'b0, 1'b1, 1'b0, 3'b101, 1, "R5 all one", 0);
    run_case(1'b1, 1'b0, 1'b1, 3'b010, 1, "R5 all zero", 0);
    run_case(1'b0, 1'b0, 1'b0, 3'b000, 1, "R9 busy start pref0", 1);
    run_case(1'b1, 1'b0, 1'b0, 3'b100, 1, "R9 busy start pref1", 1);
    chk(status[0] == 1'b0 && status[2] == 1'b1, "R2 field layout", status, 4);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule